// File: doc/BRIEF.md
# Transmit Header Insertion Scheduler

This block turns transfer commands into outgoing Ethernet frames toward the host. A command names a source port, a payload length in bytes and the start address of the payload in memory. Ports 0 to 3 are application ports and ports 4 to 15 belong to the register core. All sixteen use the same header logic. The port number selects one entry of a sixteen-deep configuration table. The entry holds the two MAC addresses, the two IP addresses, a UDP port number and two flags. The flags choose whether IP/UDP headers are inserted and whether a stream framing word is placed ahead of the payload.

One command may wait behind the frame in flight. When that command is accepted, its table entry is read and its complete header is assembled into the waiting slot. This happens while the current payload is still being fetched. The next frame can therefore begin on the cycle after the current frame's last byte. Payload bytes are pulled from memory through a request/ready pair. Every byte leaves on a byte stream with valid, ready and last.

Top module: `txhdr_sched`

## Requirements
- R1: A command is taken on a clock edge where `cmd_valid` and `cmd_ready` are both high. At most one command waits behind the active frame, and `cmd_ready` is low while that waiting slot is occupied.
- R2: Every frame begins with the 6 destination MAC bytes and then the 6 source MAC bytes of the command's port entry, most significant byte first.
- R3: When the entry's IP flag is 1, the MAC bytes are followed by 16 bytes in this order:
  - the destination IP (4 bytes);
  - the source IP (4 bytes);
  - the entry's UDP port, twice (2 bytes each);
  - the UDP length, equal to 8 + payload size, plus 4 when the stream flag is set (2 bytes);
  - a checksum of 0x0000 (2 bytes).
  All fields are most significant byte first.
- R4: When the IP flag is 0, the byte after the source MAC is the first byte of the stream word, or the first payload byte if there is no stream word.
- R5: When the stream flag is 1, a 4-byte word {0x1C, port zero-extended to 8 bits, size[15:8], size[7:0]} comes directly before the payload. When the flag is 0, no such word is sent.
- R6: Payload byte k is read from address ptr+k. A byte moves on a cycle where `mem_req` and `mem_rdy` are both high. `mem_req` is raised only while the output register can take a byte.
- R7: `out_last` is high on the final payload byte only. For a zero-length command it marks the final header byte instead.
- R8: While `out_valid` is high and `out_ready` is low, `out_valid`, `out_data` and `out_last` hold steady.
- R9: A port's table entry is captured when the command is accepted. Later writes to that entry do not change a frame that is already queued or active.
- R10: A second command can be queued while the first frame is still sending. If `out_ready` and `mem_rdy` stay high, the first byte of the second frame then follows the last byte of the first frame on the very next cycle.
- R11: During reset `out_valid` and `mem_req` are low and `cmd_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_we | input | 1 | Write strobe for the port table |
| cfg_port | input | PORT_W | Table entry to write |
| cfg_mac_dst | input | 48 | Destination MAC for the entry |
| cfg_mac_src | input | 48 | Source MAC for the entry |
| cfg_ip_dst | input | 32 | Destination IP for the entry |
| cfg_ip_src | input | 32 | Source IP for the entry |
| cfg_udp_port | input | 16 | UDP port number for the entry |
| cfg_ip_en | input | 1 | Insert IP/UDP headers |
| cfg_strm_en | input | 1 | Insert the stream framing word |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Command slot free |
| cmd_port | input | PORT_W | Port of the command |
| cmd_size | input | SIZE_W | Payload length in bytes |
| cmd_ptr | input | PTR_W | Payload start address |
| mem_req | output | 1 | Request for the byte at `mem_addr` |
| mem_addr | output | PTR_W | Address of the requested byte |
| mem_rdy | input | 1 | Memory presents the requested byte |
| mem_data | input | 8 | Byte from memory |
| out_valid | output | 1 | Output byte valid |
| out_ready | input | 1 | Sink takes the byte |
| out_data | output | 8 | Output byte |
| out_last | output | 1 | Final byte of the frame |

## Verification
The hardest situation to reach is a command waiting in the slot while its port entry is rewritten. Reaching it needs the active frame to be held open long enough to queue a second command and then change its configuration. The bench drops `mem_rdy` so the first frame stalls right after its header. It then queues a second command, confirms `cmd_ready` has fallen, rewrites that command's entry, and releases memory. The second frame must still carry the old addresses, and a later command on the same port must carry the new ones. The gapless hand-over is checked separately by queuing two frames with memory and sink always ready, and by comparing the cycle numbers of the adjoining bytes.

// File: rtl/txhdr_pkg.sv
package txhdr_pkg;
    localparam int MAC_B  = 12;
    localparam int IP_B   = 16;
    localparam int SW_B   = 4;
    localparam int UDP_B  = 8;
    localparam int HDR_MAX = MAC_B + IP_B + SW_B;
    localparam int HDR_W  = HDR_MAX * 8;
    localparam int HLEN_W = $clog2(HDR_MAX + 1);
    localparam logic [7:0] STRM_TAG = 8'h1C;

    typedef struct packed {
        logic [47:0] mac_dst;
        logic [47:0] mac_src;
        logic [31:0] ip_dst;
        logic [31:0] ip_src;
        logic [15:0] udp_port;
        logic        ip_en;
        logic        strm_en;
    } port_cfg_t;

    typedef logic [HDR_W-1:0] hdr_vec_t;
endpackage

// File: rtl/txhdr_cfg_table.sv
module txhdr_cfg_table
    import txhdr_pkg::*;
#(
    parameter int PORT_W = 4,
    localparam int DEPTH = 2 ** PORT_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [PORT_W-1:0] wr_port,
    input  port_cfg_t         wr_entry,
    input  logic [PORT_W-1:0] rd_port,
    output port_cfg_t         rd_entry
);
    port_cfg_t slot_q [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        port_cfg_t slot_d;
        always_comb begin
            slot_d = slot_q[g];
            if (wr_en && (wr_port == PORT_W'(g)))
                slot_d = wr_entry;
        end
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) slot_q[g] <= '0;
            else        slot_q[g] <= slot_d;
        end
    end

    assign rd_entry = slot_q[rd_port];
endmodule

// File: rtl/txhdr_hdr_build.sv
module txhdr_hdr_build
    import txhdr_pkg::*;
#(
    parameter int PORT_W = 4,
    parameter int SIZE_W = 16
) (
    input  port_cfg_t         entry,
    input  logic [PORT_W-1:0] port,
    input  logic [SIZE_W-1:0] size,
    output hdr_vec_t          hdr,
    output logic [HLEN_W-1:0] hdr_len
);
    logic [MAC_B*8-1:0] mac_part;
    logic [IP_B*8-1:0]  ip_part;
    logic [SW_B*8-1:0]  strm_word;
    logic [15:0]        size16;
    logic [15:0]        udp_len;

    always_comb begin
        size16    = 16'(size);
        udp_len   = 16'(UDP_B) + (entry.strm_en ? 16'(SW_B) : 16'd0) + size16;
        mac_part  = {entry.mac_dst, entry.mac_src};
        ip_part   = {entry.ip_dst, entry.ip_src, entry.udp_port,
                     entry.udp_port, udp_len, 16'h0000};
        strm_word = {STRM_TAG, 8'(port), size16};
        unique case ({entry.ip_en, entry.strm_en})
            2'b00: begin
                hdr     = {mac_part, {(IP_B + SW_B)*8{1'b0}}};
                hdr_len = HLEN_W'(MAC_B);
            end
            2'b01: begin
                hdr     = {mac_part, strm_word, {IP_B*8{1'b0}}};
                hdr_len = HLEN_W'(MAC_B + SW_B);
            end
            2'b10: begin
                hdr     = {mac_part, ip_part, {SW_B*8{1'b0}}};
                hdr_len = HLEN_W'(MAC_B + IP_B);
            end
            default: begin
                hdr     = {mac_part, ip_part, strm_word};
                hdr_len = HLEN_W'(HDR_MAX);
            end
        endcase
    end
endmodule

// File: rtl/txhdr_sched.sv
module txhdr_sched
    import txhdr_pkg::*;
#(
    parameter int PORT_W = 4,
    parameter int SIZE_W = 16,
    parameter int PTR_W  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [PORT_W-1:0] cfg_port,
    input  logic [47:0]       cfg_mac_dst,
    input  logic [47:0]       cfg_mac_src,
    input  logic [31:0]       cfg_ip_dst,
    input  logic [31:0]       cfg_ip_src,
    input  logic [15:0]       cfg_udp_port,
    input  logic              cfg_ip_en,
    input  logic              cfg_strm_en,
    input  logic              cmd_valid,
    output logic              cmd_ready,
    input  logic [PORT_W-1:0] cmd_port,
    input  logic [SIZE_W-1:0] cmd_size,
    input  logic [PTR_W-1:0]  cmd_ptr,
    output logic              mem_req,
    output logic [PTR_W-1:0]  mem_addr,
    input  logic              mem_rdy,
    input  logic [7:0]        mem_data,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [7:0]        out_data,
    output logic              out_last
);
    typedef struct packed {
        logic              pend_v;
        hdr_vec_t          pend_hdr;
        logic [HLEN_W-1:0] pend_hlen;
        logic [SIZE_W-1:0] pend_size;
        logic [PTR_W-1:0]  pend_ptr;
        logic              act_v;
        hdr_vec_t          act_hdr;
        logic [HLEN_W-1:0] act_hlen;
        logic [SIZE_W-1:0] act_size;
        logic [PTR_W-1:0]  act_addr;
        logic [HLEN_W-1:0] hcnt;
        logic [SIZE_W-1:0] pcnt;
        logic              pay_ph;
        logic              out_v;
        logic [7:0]        out_byte;
        logic              out_end;
    } st_t;

    st_t st_q, st_d;

    port_cfg_t         wr_entry, rd_entry;
    hdr_vec_t          bld_hdr;
    logic [HLEN_W-1:0] bld_len;

    assign wr_entry = '{mac_dst: cfg_mac_dst, mac_src: cfg_mac_src,
                        ip_dst: cfg_ip_dst, ip_src: cfg_ip_src,
                        udp_port: cfg_udp_port, ip_en: cfg_ip_en,
                        strm_en: cfg_strm_en};

    txhdr_cfg_table #(.PORT_W(PORT_W)) u_table (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (cfg_we),
        .wr_port  (cfg_port),
        .wr_entry (wr_entry),
        .rd_port  (cmd_port),
        .rd_entry (rd_entry)
    );

    txhdr_hdr_build #(.PORT_W(PORT_W), .SIZE_W(SIZE_W)) u_build (
        .entry   (rd_entry),
        .port    (cmd_port),
        .size    (cmd_size),
        .hdr     (bld_hdr),
        .hdr_len (bld_len)
    );

    logic can_load, hdr_fire, pay_fire, frame_done;

    always_comb begin
        st_d       = st_q;
        can_load   = !st_q.out_v || out_ready;
        hdr_fire   = st_q.act_v && !st_q.pay_ph && can_load;
        pay_fire   = st_q.act_v && st_q.pay_ph && can_load && mem_rdy;
        frame_done = 1'b0;

        if (can_load)
            st_d.out_v = hdr_fire || pay_fire;

        if (hdr_fire) begin
            st_d.out_byte = st_q.act_hdr[HDR_W-1 -: 8];
            st_d.act_hdr  = st_q.act_hdr << 8;
            st_d.hcnt     = st_q.hcnt + 1'b1;
            st_d.out_end  = 1'b0;
            if (st_q.hcnt == st_q.act_hlen - 1'b1) begin
                if (st_q.act_size == '0) begin
                    st_d.out_end = 1'b1;
                    frame_done   = 1'b1;
                end else begin
                    st_d.pay_ph  = 1'b1;
                end
            end
        end

        if (pay_fire) begin
            st_d.out_byte = mem_data;
            st_d.act_addr = st_q.act_addr + 1'b1;
            st_d.pcnt     = st_q.pcnt + 1'b1;
            st_d.out_end  = 1'b0;
            if (st_q.pcnt == st_q.act_size - 1'b1) begin
                st_d.out_end = 1'b1;
                frame_done   = 1'b1;
            end
        end

        if ((frame_done || !st_q.act_v) && st_q.pend_v) begin
            st_d.act_v    = 1'b1;
            st_d.act_hdr  = st_q.pend_hdr;
            st_d.act_hlen = st_q.pend_hlen;
            st_d.act_size = st_q.pend_size;
            st_d.act_addr = st_q.pend_ptr;
            st_d.hcnt     = '0;
            st_d.pcnt     = '0;
            st_d.pay_ph   = 1'b0;
            st_d.pend_v   = 1'b0;
        end else if (frame_done) begin
            st_d.act_v    = 1'b0;
            st_d.pay_ph   = 1'b0;
        end

        if (cmd_valid && !st_q.pend_v) begin
            st_d.pend_v    = 1'b1;
            st_d.pend_hdr  = bld_hdr;
            st_d.pend_hlen = bld_len;
            st_d.pend_size = cmd_size;
            st_d.pend_ptr  = cmd_ptr;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cmd_ready = !st_q.pend_v;
    assign mem_req   = st_q.act_v && st_q.pay_ph && can_load;
    assign mem_addr  = st_q.act_addr;
    assign out_valid = st_q.out_v;
    assign out_data  = st_q.out_byte;
    assign out_last  = st_q.out_end;
endmodule

// File: rtl/txhdr_sched_chk.sv
module txhdr_sched_chk #(
    parameter int PTR_W = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cmd_valid,
    input logic             cmd_ready,
    input logic             mem_req,
    input logic             mem_rdy,
    input logic [PTR_W-1:0] mem_addr,
    input logic             out_valid,
    input logic             out_ready,
    input logic [7:0]       out_data,
    input logic             out_last
);
    p_slot_fills_r1: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid && cmd_ready |=> !cmd_ready);

    p_req_room_r6: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> (!out_valid || out_ready));

    p_addr_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && mem_rdy |=> !mem_req || (mem_addr == $past(mem_addr) + 1'b1));

    p_last_ends_fetch_r7: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_ready && out_last |=> !mem_req);

    p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_last));
endmodule

bind txhdr_sched txhdr_sched_chk #(.PTR_W(PTR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_valid (cmd_valid),
    .cmd_ready (cmd_ready),
    .mem_req   (mem_req),
    .mem_rdy   (mem_rdy),
    .mem_addr  (mem_addr),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (out_data),
    .out_last  (out_last)
);

// File: tb/txhdr_sched_bench.sv
`timescale 1ns/1ps
module txhdr_sched_bench;
    localparam int PORT_W = 4;
    localparam int SIZE_W = 16;
    localparam int PTR_W  = 32;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic              rst_n;
    logic              cfg_we;
    logic [PORT_W-1:0] cfg_port;
    logic [47:0]       cfg_mac_dst, cfg_mac_src;
    logic [31:0]       cfg_ip_dst, cfg_ip_src;
    logic [15:0]       cfg_udp_port;
    logic              cfg_ip_en, cfg_strm_en;
    logic              cmd_valid, cmd_ready;
    logic [PORT_W-1:0] cmd_port;
    logic [SIZE_W-1:0] cmd_size;
    logic [PTR_W-1:0]  cmd_ptr;
    logic              mem_req, mem_rdy;
    logic [PTR_W-1:0]  mem_addr;
    logic [7:0]        mem_data;
    logic              out_valid, out_ready, out_last;
    logic [7:0]        out_data;

    txhdr_sched #(.PORT_W(PORT_W), .SIZE_W(SIZE_W), .PTR_W(PTR_W)) u_txhdr_sched (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_port(cfg_port),
        .cfg_mac_dst(cfg_mac_dst), .cfg_mac_src(cfg_mac_src),
        .cfg_ip_dst(cfg_ip_dst), .cfg_ip_src(cfg_ip_src),
        .cfg_udp_port(cfg_udp_port), .cfg_ip_en(cfg_ip_en), .cfg_strm_en(cfg_strm_en),
        .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_port(cmd_port),
        .cmd_size(cmd_size), .cmd_ptr(cmd_ptr), .mem_req(mem_req),
        .mem_addr(mem_addr), .mem_rdy(mem_rdy), .mem_data(mem_data),
        .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
        .out_last(out_last)
    );

    function automatic logic [7:0] mem_byte(input logic [PTR_W-1:0] a);
        return a[7:0] ^ a[15:8] ^ 8'h3C;
    endfunction
    assign mem_data = mem_byte(mem_addr);

    typedef struct {
        logic [7:0] d;
        logic       l;
        logic       gap;
        string      req;
    } exp_t;

    exp_t expq[$];
    int   total = 0;
    int   bad   = 0;
    int   cyc   = 0;
    int   last_cyc = 0;
    int   mem_mode = 0;
    int   out_mode = 0;
    bit   finished = 0;
    logic [15:0] lfsr = 16'hACE1;

    logic [47:0] sh_mdst [16];
    logic [47:0] sh_msrc [16];
    logic [31:0] sh_idst [16];
    logic [31:0] sh_isrc [16];
    logic [15:0] sh_udp  [16];
    logic        sh_ip   [16];
    logic        sh_st   [16];

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic push(input logic [7:0] d, input string req);
        exp_t e;
        e.d = d; e.l = 1'b0; e.gap = 1'b0; e.req = req;
        expq.push_back(e);
    endtask

    task automatic push_frame(input int p, input int size, input logic [PTR_W-1:0] ptr,
                              input bit gap);
        int first = expq.size();
        logic [15:0] ulen = 16'(8 + size + (sh_st[p] ? 4 : 0));
        for (int i = 0; i < 6; i++) push(sh_mdst[p][8*(5-i) +: 8], "R2");
        for (int i = 0; i < 6; i++) push(sh_msrc[p][8*(5-i) +: 8], "R2");
        if (sh_ip[p]) begin
            for (int i = 0; i < 4; i++) push(sh_idst[p][8*(3-i) +: 8], "R3");
            for (int i = 0; i < 4; i++) push(sh_isrc[p][8*(3-i) +: 8], "R3");
            for (int i = 0; i < 2; i++) begin
                push(sh_udp[p][15:8], "R3");
                push(sh_udp[p][7:0], "R3");
            end
            push(ulen[15:8], "R3");
            push(ulen[7:0], "R3");
            push(8'h00, "R3");
            push(8'h00, "R3");
        end
        if (sh_st[p]) begin
            push(8'h1C, sh_ip[p] ? "R5" : "R4");
            push(8'(p), "R5");
            push(8'(size >> 8), "R5");
            push(8'(size), "R5");
        end
        for (int i = 0; i < size; i++)
            push(mem_byte(ptr + PTR_W'(i)), (i == 0 && !sh_ip[p] && !sh_st[p]) ? "R4" : "R6");
        expq[expq.size()-1].l = 1'b1;
        if (size == 0) expq[expq.size()-1].req = "R7";
        expq[first].gap = gap;
    endtask

    task automatic cfg_write(input int p, input logic [47:0] md, input logic [47:0] ms,
                             input logic [31:0] id, input logic [31:0] is,
                             input logic [15:0] up, input bit ip, input bit st);
        @(negedge clk);
        cfg_we = 1'b1; cfg_port = PORT_W'(p);
        cfg_mac_dst = md; cfg_mac_src = ms; cfg_ip_dst = id; cfg_ip_src = is;
        cfg_udp_port = up; cfg_ip_en = ip; cfg_strm_en = st;
        sh_mdst[p] = md; sh_msrc[p] = ms; sh_idst[p] = id; sh_isrc[p] = is;
        sh_udp[p] = up; sh_ip[p] = ip; sh_st[p] = st;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic send_cmd(input int p, input int size, input logic [PTR_W-1:0] ptr,
                            input bit gap);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_port = PORT_W'(p);
        cmd_size = SIZE_W'(size); cmd_ptr = ptr;
        #1;
        while (!cmd_ready) begin
            @(negedge clk);
            #1;
        end
        push_frame(p, size, ptr, gap);
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    task automatic drain();
        while (expq.size() != 0 || out_valid) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cyc++;
        end
    end

    initial begin
        mem_rdy = 1'b0;
        out_ready = 1'b0;
        forever begin
            @(negedge clk);
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            mem_rdy   = (mem_mode == 0) ? 1'b1 : (mem_mode == 1) ? lfsr[0] : 1'b0;
            out_ready = (out_mode == 0) ? 1'b1 : lfsr[5];
        end
    end

    initial begin
        exp_t e;
        forever begin
            @(negedge clk);
            #1;
            if (rst_n && out_valid && out_ready) begin
                if (expq.size() == 0) begin
                    chk(1'b0, "R6", "unexpected byte", 64'(out_data), 64'h0);
                end else begin
                    e = expq.pop_front();
                    chk(out_data === e.d, e.req, "data", 64'(out_data), 64'(e.d));
                    chk(out_last === e.l, "R7", "last", 64'(out_last), 64'(e.l));
                    if (e.gap)
                        chk(cyc == last_cyc + 1, "R10", "gap cycles", 64'(cyc - last_cyc), 64'd1);
                    if (out_last) last_cyc = cyc;
                end
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", expq.size(), 0);
        finish_run();
    end

    initial begin
        rst_n = 1'b0; cfg_we = 1'b0; cfg_port = '0;
        cfg_mac_dst = '0; cfg_mac_src = '0; cfg_ip_dst = '0; cfg_ip_src = '0;
        cfg_udp_port = '0; cfg_ip_en = 1'b0; cfg_strm_en = 1'b0;
        cmd_valid = 1'b0; cmd_port = '0; cmd_size = '0; cmd_ptr = '0;
        repeat (4) @(negedge clk);
        // R11: reset state
        chk(out_valid == 1'b0, "R11", "out_valid", 64'(out_valid), 64'd0);
        chk(mem_req == 1'b0, "R11", "mem_req", 64'(mem_req), 64'd0);
        chk(cmd_ready == 1'b1, "R11", "cmd_ready", 64'(cmd_ready), 64'd1);
        rst_n = 1'b1;

        cfg_write(0, 48'h0A0B0C0D0E0F, 48'h111213141516, 32'hC0A80001, 32'hC0A80002, 16'd1000, 0, 0);
        cfg_write(1, 48'hFFFFFFFFFFFF, 48'h020000000001, 32'h0A000001, 32'h0A000002, 16'd1001, 1, 0);
        cfg_write(2, 48'h3C4D5E6F7081, 48'h92A3B4C5D6E7, 32'h01020304, 32'h05060708, 16'h1234, 0, 1);
        cfg_write(3, 48'hDEADBEEF0001, 48'hCAFEF00D0002, 32'hAC100001, 32'hAC100002, 16'hBEEF, 1, 1);
        cfg_write(9, 48'h5555AAAA5555, 48'hAAAA5555AAAA, 32'h7F000001, 32'h7F000002, 16'h0F0F, 1, 1);

        // R2 R4 R6 R7: plain MAC frame
        send_cmd(0, 5, 32'h0000_0010, 0);
        drain();
        // R3: IP/UDP headers
        send_cmd(1, 3, 32'h0000_0200, 0);
        drain();
        // R5: stream word without IP
        send_cmd(2, 4, 32'h0000_0333, 0);
        drain();
        // R3 R5: both
        send_cmd(3, 7, 32'h0001_0000, 0);
        drain();

        // R10: second command queued during first payload
        send_cmd(1, 20, 32'h0000_0100, 0);
        send_cmd(3, 6, 32'h0000_2000, 1);
        drain();

        // R8 R6: random stalls on both sides
        mem_mode = 1; out_mode = 1;
        send_cmd(9, 17, 32'h0000_4FF8, 0);
        send_cmd(0, 1, 32'h0000_0077, 0);
        send_cmd(2, 9, 32'h0000_0ABC, 0);
        send_cmd(3, 12, 32'h0000_1234, 0);
        drain();
        mem_mode = 0; out_mode = 0;

        // R7: zero-length command
        send_cmd(1, 0, 32'h0000_0000, 0);
        drain();

        // R1 R9: queue behind a stalled frame, then rewrite the queued port
        mem_mode = 2;
        send_cmd(2, 3, 32'h0000_0040, 0);
        send_cmd(3, 2, 32'h0000_0050, 0);
        repeat (3) @(negedge clk);
        #1;
        chk(cmd_ready == 1'b0, "R1", "cmd_ready with slot full", 64'(cmd_ready), 64'd0);
        cfg_write(3, 48'h0102030405AA, 48'h0102030405BB, 32'h99999999, 32'h88888888, 16'h4321, 0, 1);
        mem_mode = 0;
        drain();
        // R9: new entry contents seen by a later command
        send_cmd(3, 2, 32'h0000_0060, 0);
        drain();

        chk(expq.size() == 0, "R6", "bytes still expected", 64'(expq.size()), 64'd0);
        finish_run();
    end
endmodule